// File: doc/BRIEF.md
# Trap Routing and Vector Generator

This block decides where a trap is delivered and computes the handler entry address for it. For each trap it receives the trap type, the current trap level, the privilege and hyper-privilege bits, the red-mode bit, the two trap base addresses, and a small per-trap map that names the destination mode for each possible current mode. It reports four things:
- the delivery path: red, error, hyperprivileged or privileged;
- the effective trap type used to build the vector;
- the handler PC;
- the following PC.

Saving architectural state is left to the surrounding logic.

A trap request is a single transaction on a valid/ready input. The routed result appears one cycle after acceptance on a valid/ready output held by a one-entry register. While a result waits and `out_ready` is low, the result is held unchanged and `in_ready` is low, so no new trap is accepted. When `out_ready` is high, a new request can be accepted on the same edge that retires the held result.

Top module: `trap_router`

## Requirements
- R1: The current mode is hyperprivileged (index 2) when `hpstate_hpriv` is 1, otherwise privileged (index 1) when `pstate_priv` is 1, otherwise user (index 0). The destination for the trap is `target_map[index]`, where 1 means hyperprivileged and 0 means privileged.
- R2: When `hpstate_red` is 1 or `trap_level` equals MAX_TL-1, the path is red (`out_path`=0) and the effective type is 5. The PC is RED_BASE OR ((5<<5) AND 0xFF), which with the default base is 0xFFF00000A0. This case wins over all the others.
- R3: Otherwise, when `trap_level` is MAX_TL or higher, the path is error (`out_path`=1), the effective type is the input trap type, and the PC is 0.
- R4: Otherwise, when `trap_level` is above MAX_PTL and the destination is privileged, the path is hyperprivileged (`out_path`=2) and the effective type is 2.
- R5: Otherwise, the path is hyperprivileged with the input trap type when the destination is hyperprivileged, or when the destination is privileged and the trap type is 384 or more.
- R6: On the hyperprivileged path the PC is `htba` with bits 13:0 cleared, ORed with (effective type << 5) kept to 14 bits.
- R7: In all other cases the path is privileged (`out_path`=3) with the input trap type. The PC is `tba` with bits 14:0 cleared, ORed with (type << 5) kept to 14 bits, and with bit 14 set when `trap_level`+1 is above 1.
- R8: On every path, `out_npc` equals `out_pc` + 4.
- R9: After reset `out_valid` is 0. An accepted request (`in_valid` and `in_ready` both 1) produces `out_valid`=1 after the next clock edge. No result appears without an accepted request.
- R10: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value and `in_ready` is 0. `in_ready` is 1 whenever no result is waiting or `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Trap request present |
| in_ready | output | 1 | Request can be accepted |
| trap_type | input | TT_W (9) | Trap type of the request |
| trap_level | input | TL_W (3) | Current trap level |
| pstate_priv | input | 1 | Privilege bit |
| hpstate_hpriv | input | 1 | Hyper-privilege bit |
| hpstate_red | input | 1 | Red-mode bit |
| target_map | input | 3 | Destination per current mode, 1 = hyperprivileged |
| tba | input | ADDR_W (64) | Privileged trap base address |
| htba | input | ADDR_W (64) | Hyperprivileged trap base address |
| out_valid | output | 1 | Routed result present |
| out_ready | input | 1 | Consumer takes the result |
| out_path | output | 2 | 0 red, 1 error, 2 hyperprivileged, 3 privileged |
| out_tt | output | TT_W (9) | Effective trap type |
| out_pc | output | ADDR_W (64) | Handler PC |
| out_npc | output | ADDR_W (64) | Handler next PC |

## Verification
The hardest cases to reach are where the trap-level thresholds overlap each other:
- red mode at a level that would otherwise be the error level;
- the guest-watchdog redirect against a trap type of 384 or more;
- the bit-14 offset at trap level zero.

The bench reaches all of them by sweeping every trap level, including levels above MAX_TL, every mode-bit pair, both red values and all eight target maps against a set of trap types on both sides of 384. Each case is checked against vectors computed arithmetically, with base addresses that change per case. A separate stall sequence holds `out_ready` low to check that the result is held.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {
    PATH_RED  = 2'd0,
    PATH_ERR  = 2'd1,
    PATH_HYP  = 2'd2,
    PATH_PRIV = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_PRIV = 2'd1,
    MODE_HYP  = 2'd2
  } mode_e;

  localparam int unsigned INSN_SHIFT = 5;
  localparam int unsigned VEC_OFF_W  = 14;
  localparam int unsigned RED_OFF_W  = 8;
  localparam int unsigned RED_TT     = 5;
  localparam int unsigned WDOG_TT    = 2;
  localparam int unsigned HYP_TT_MIN = 384;
  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/trap_mode_decode.sv
module trap_mode_decode
  import trap_pkg::*;
(
  input  logic       hpriv_bit,
  input  logic       priv_bit,
  input  logic [2:0] dest_map,
  output mode_e      cur_mode,
  output logic       dest_hyp
);
  always_comb begin
    if (hpriv_bit)     cur_mode = MODE_HYP;
    else if (priv_bit) cur_mode = MODE_PRIV;
    else               cur_mode = MODE_USER;
  end

  always_comb begin
    unique case (cur_mode)
      MODE_HYP:  dest_hyp = dest_map[2];
      MODE_PRIV: dest_hyp = dest_map[1];
      default:   dest_hyp = dest_map[0];
    endcase
  end
endmodule

// File: rtl/trap_path_select.sv
module trap_path_select
  import trap_pkg::*;
#(
  parameter int unsigned TT_W    = 9,
  parameter int unsigned TL_W    = 3,
  parameter int unsigned MAX_TL  = 6,
  parameter int unsigned MAX_PTL = 2
) (
  input  logic [TT_W-1:0] tt_in,
  input  logic [TL_W-1:0] tl_in,
  input  logic            red_bit,
  input  logic            dest_hyp,
  output path_e           path,
  output logic [TT_W-1:0] eff_tt,
  output logic            tl_nonzero
);
  localparam logic [TL_W-1:0] TL_RED  = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] TL_ERR  = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_PMAX = TL_W'(MAX_PTL);
  localparam logic [TT_W-1:0] TT_HMIN = TT_W'(HYP_TT_MIN);

  logic go_red, go_err, go_wdog, go_hyp;

  assign go_red  = red_bit || (tl_in == TL_RED);
  assign go_err  = (tl_in >= TL_ERR);
  assign go_wdog = (tl_in > TL_PMAX) && !dest_hyp;
  assign go_hyp  = dest_hyp || (tt_in >= TT_HMIN);
  assign tl_nonzero = (tl_in != '0);

  always_comb begin
    path   = PATH_PRIV;
    eff_tt = tt_in;
    if (go_red) begin
      path   = PATH_RED;
      eff_tt = TT_W'(RED_TT);
    end else if (go_err) begin
      path   = PATH_ERR;
    end else if (go_wdog) begin
      path   = PATH_HYP;
      eff_tt = TT_W'(WDOG_TT);
    end else if (go_hyp) begin
      path   = PATH_HYP;
    end
  end
endmodule

// File: rtl/trap_vector_gen.sv
module trap_vector_gen
  import trap_pkg::*;
#(
  parameter int unsigned TT_W     = 9,
  parameter int unsigned ADDR_W   = 64,
  parameter logic [63:0] RED_BASE = 64'h0000_00FF_F000_0000
) (
  input  path_e             path,
  input  logic [TT_W-1:0]   eff_tt,
  input  logic [ADDR_W-1:0] tba,
  input  logic [ADDR_W-1:0] htba,
  input  logic              tl_nonzero,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] npc
);
  localparam logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'((64'd1 << VEC_OFF_W) - 1);
  localparam logic [ADDR_W-1:0] PRIV_MASK = ADDR_W'((64'd1 << (VEC_OFF_W + 1)) - 1);
  localparam logic [ADDR_W-1:0] RED_MASK  = ADDR_W'((64'd1 << RED_OFF_W) - 1);
  localparam logic [ADDR_W-1:0] TL_BIT    = ADDR_W'(64'd1 << VEC_OFF_W);

  logic [ADDR_W-1:0] tt_shifted;
  logic [ADDR_W-1:0] hyp_vec, priv_vec, red_vec;

  assign tt_shifted = ADDR_W'(eff_tt) << INSN_SHIFT;
  assign hyp_vec  = (htba & ~OFF_MASK) | (tt_shifted & OFF_MASK);
  assign priv_vec = (tba & ~PRIV_MASK) | (tl_nonzero ? TL_BIT : '0)
                  | (tt_shifted & OFF_MASK);
  assign red_vec  = ADDR_W'(RED_BASE) | (tt_shifted & RED_MASK);

  always_comb begin
    unique case (path)
      PATH_RED: pc = red_vec;
      PATH_HYP: pc = hyp_vec;
      PATH_ERR: pc = '0;
      default:  pc = priv_vec;
    endcase
  end

  assign npc = pc + ADDR_W'(INSN_BYTES);
endmodule

// File: rtl/trap_router.sv
module trap_router
  import trap_pkg::*;
#(
  parameter int unsigned TT_W     = 9,
  parameter int unsigned TL_W     = 3,
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned MAX_TL   = 6,
  parameter int unsigned MAX_PTL  = 2,
  parameter logic [63:0] RED_BASE = 64'h0000_00FF_F000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TT_W-1:0]   trap_type,
  input  logic [TL_W-1:0]   trap_level,
  input  logic              pstate_priv,
  input  logic              hpstate_hpriv,
  input  logic              hpstate_red,
  input  logic [2:0]        target_map,
  input  logic [ADDR_W-1:0] tba,
  input  logic [ADDR_W-1:0] htba,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_path,
  output logic [TT_W-1:0]   out_tt,
  output logic [ADDR_W-1:0] out_pc,
  output logic [ADDR_W-1:0] out_npc
);
  mode_e             cur_mode;
  logic              dest_hyp;
  path_e             sel_path;
  logic [TT_W-1:0]   sel_tt;
  logic              tl_nonzero;
  logic [ADDR_W-1:0] vec_pc, vec_npc;
  logic              take;

  trap_mode_decode u_mode (
    .hpriv_bit (hpstate_hpriv),
    .priv_bit  (pstate_priv),
    .dest_map  (target_map),
    .cur_mode  (cur_mode),
    .dest_hyp  (dest_hyp)
  );

  trap_path_select #(
    .TT_W(TT_W), .TL_W(TL_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)
  ) u_sel (
    .tt_in      (trap_type),
    .tl_in      (trap_level),
    .red_bit    (hpstate_red),
    .dest_hyp   (dest_hyp),
    .path       (sel_path),
    .eff_tt     (sel_tt),
    .tl_nonzero (tl_nonzero)
  );

  trap_vector_gen #(
    .TT_W(TT_W), .ADDR_W(ADDR_W), .RED_BASE(RED_BASE)
  ) u_vec (
    .path       (sel_path),
    .eff_tt     (sel_tt),
    .tba        (tba),
    .htba       (htba),
    .tl_nonzero (tl_nonzero),
    .pc         (vec_pc),
    .npc        (vec_npc)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_path <= '0;
      out_tt   <= '0;
      out_pc   <= '0;
      out_npc  <= '0;
    end else if (take) begin
      out_path <= sel_path;
      out_tt   <= sel_tt;
      out_pc   <= vec_pc;
      out_npc  <= vec_npc;
    end
  end
endmodule

// File: rtl/trap_router_chk.sv
module trap_router_chk #(
  parameter int unsigned TT_W   = 9,
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_path,
  input logic [TT_W-1:0]   out_tt,
  input logic [ADDR_W-1:0] out_pc,
  input logic [ADDR_W-1:0] out_npc
);
  // R9
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pc)
      && $stable(out_path) && $stable(out_tt) && $stable(out_npc)));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  npc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_npc == out_pc + ADDR_W'(4)));

  // R2
  red_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_path == 2'd0) |-> (out_tt == TT_W'(5)));

  // R3
  err_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_path == 2'd1) |-> (out_pc == '0));

  // R6
  hyp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_path == 2'd2) |-> (out_pc[4:0] == 5'd0));
endmodule

bind trap_router trap_router_chk #(.TT_W(TT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_path  (out_path),
  .out_tt    (out_tt),
  .out_pc    (out_pc),
  .out_npc   (out_npc)
);

// File: tb/trap_router_tb.sv
module trap_router_tb;
  localparam int unsigned TT_W = 9, TL_W = 3, AW = 64;
  localparam int unsigned MAXTL = 6, MAXPTL = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid;
  logic [TT_W-1:0] trap_type = '0;
  logic [TL_W-1:0] trap_level = '0;
  logic pstate_priv = 1'b0, hpstate_hpriv = 1'b0, hpstate_red = 1'b0;
  logic [2:0] target_map = '0;
  logic [AW-1:0] tba = '0, htba = '0;
  logic [1:0] out_path;
  logic [TT_W-1:0] out_tt;
  logic [AW-1:0] out_pc, out_npc;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trap_router u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .trap_type(trap_type), .trap_level(trap_level), .pstate_priv(pstate_priv),
    .hpstate_hpriv(hpstate_hpriv), .hpstate_red(hpstate_red),
    .target_map(target_map), .tba(tba), .htba(htba), .out_valid(out_valid),
    .out_ready(out_ready), .out_path(out_path), .out_tt(out_tt),
    .out_pc(out_pc), .out_npc(out_npc)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(input int tt, input int tl, input bit pr, input bit hp,
                       input bit rd, input int map, input logic [AW-1:0] b,
                       input logic [AW-1:0] hb, output int path, output int ett,
                       output logic [AW-1:0] pc, output string tag);
    int mode;
    bit hyp_dest;
    mode = hp ? 2 : (pr ? 1 : 0);
    hyp_dest = ((map >> mode) & 1) == 1;
    if (rd || tl == MAXTL - 1) begin
      path = 0; ett = 5; pc = 64'hFF_F000_0000 + 64'hA0; tag = "R2";
    end else if (tl >= MAXTL) begin
      path = 1; ett = tt; pc = 0; tag = "R3";
    end else if (tl > MAXPTL && !hyp_dest) begin
      path = 2; ett = 2; tag = "R1 R4 R6";
      pc = (hb / 16384) * 16384 + 64;
    end else if (hyp_dest || tt >= 384) begin
      path = 2; ett = tt; tag = "R1 R5 R6";
      pc = (hb / 16384) * 16384 + ((tt * 32) % 16384);
    end else begin
      path = 3; ett = tt; tag = "R1 R7";
      pc = (b / 32768) * 32768 + (tl + 1 > 1 ? 16384 : 0) + ((tt * 32) % 16384);
    end
  endtask

  task automatic send(input int tt, input int tl, input bit pr, input bit hp,
                      input bit rd, input int map, input logic [AW-1:0] b,
                      input logic [AW-1:0] hb);
    int ep, ett;
    logic [AW-1:0] epc;
    string tag;
    model(tt, tl, pr, hp, rd, map, b, hb, ep, ett, epc, tag);
    @(negedge clk);
    trap_type = TT_W'(tt); trap_level = TL_W'(tl); pstate_priv = pr;
    hpstate_hpriv = hp; hpstate_red = rd; target_map = 3'(map);
    tba = b; htba = hb; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R9", "out_valid", AW'(out_valid), 1);
    check(out_path == 2'(ep) && out_tt == TT_W'(ett) && out_pc == epc,
          tag, "path/tt/pc", out_pc, epc);
    check(out_npc == epc + 4, "R8", "npc", out_npc, epc + 4);
  endtask

  initial begin
    int tts[10] = '{0, 1, 2, 5, 36, 127, 383, 384, 385, 511};
    int idx = 0;
    logic [AW-1:0] b, hb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R9", "reset out_valid", AW'(out_valid), 0);
    check(in_ready === 1'b1, "R10", "reset in_ready", AW'(in_ready), 1);
    // no request -> no result
    @(negedge clk);
    check(out_valid === 1'b0, "R9", "idle out_valid", AW'(out_valid), 0);

    for (int tl = 0; tl < 8; tl++)
      for (int m = 0; m < 4; m++)
        for (int rd = 0; rd < 2; rd++)
          for (int map = 0; map < 8; map++)
            for (int k = 0; k < 10; k++) begin
              idx++;
              b  = 64'h1234_5678_9ABC_DEF0 ^ (64'(idx) * 64'h9E37_79B9_7F4A_7C15);
              hb = 64'hFEDC_BA98_7654_3210 ^ (64'(idx) * 64'hC2B2_AE3D_27D4_EB4F);
              send(tts[k], tl, m[0], m[1], rd[0], map, b, hb);
            end

    // stall: result must hold while out_ready is low (R10)
    @(negedge clk);
    trap_type = 9'd36; trap_level = 3'd1; pstate_priv = 1'b1; hpstate_hpriv = 1'b0;
    hpstate_red = 1'b0; target_map = 3'b000; tba = 64'hAAAA_0000_0000_0000;
    htba = '0; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    for (int s = 0; s < 3; s++) begin
      check(out_valid === 1'b1, "R10", "stall valid", AW'(out_valid), 1);
      check(in_ready === 1'b0, "R10", "stall in_ready", AW'(in_ready), 0);
      check(out_pc == 64'hAAAA_0000_0000_4480, "R10", "stall pc", out_pc,
            64'hAAAA_0000_0000_4480);
      // a new request during the stall must not replace the held result
      trap_type = 9'd300; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
    end
    check(out_pc == 64'hAAAA_0000_0000_4480, "R10", "stall pc after", out_pc,
          64'hAAAA_0000_0000_4480);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R10", "drain", AW'(out_valid), 0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R9 actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule